// File: doc/BRIEF.md
# Paravirtual Device Common Configuration Register Block

This block is the common configuration register file of a paravirtual PCI function. A driver reaches it over a simple word-wide register bus that carries a byte address, write data, byte enables and an access size. Through it the driver reads the device's 64-bit feature set one 32-bit window at a time and writes back the features it accepts, also one window at a time. It also writes a configuration interrupt vector and a device status byte, and it reads how many queues exist.

Each queue has its own bank of settings: ring size, interrupt vector, enable flag, and the addresses of the descriptor table, the available ring and the used ring. One queue-select register chooses which bank the driver sees. Every bank, the accepted features, the status byte and the configuration vector are exported in parallel to the device core. All multi-byte fields are little-endian. A field sits on the byte lanes given by the low two address bits and must be accessed at its natural width.

Top module: `pvdev_common_cfg`

## Requirements
- R1: An access takes effect only if three things match the field at the address: the size (0 byte, 1 half, 2 word), the byte enables (1, 3 or F shifted by address bits [1:0]), and the field's natural width. Otherwise a write is ignored and a read returns 0. Every read returns its data on the byte lanes of the field, with bus_rvalid high, in the cycle after the request.
- R2: Device feature select (word at 0x00) = 0 makes the device feature word (0x04) show feature bits 31:0. A select of 1 shows bits 63:32. Any other select value reads 0.
- R3: Device feature bit 32 always reads as 1, whatever the DEV_FEATURES parameter holds.
- R4: Driver feature select (word at 0x08) = 0 or 1 maps the driver feature word (0x0C) onto accepted bits 31:0 or 63:32. For any other select, writes to 0x0C are ignored and reads return 0.
- R5: Queue count (half at 0x12) reads NUM_QUEUES. Writes to it, to the device feature word and to the notify offset have no effect.
- R6: After reset every queue size (half at 0x18) reads QSIZE_MAX. A write is kept only if it is 0, or a power of two not above QSIZE_MAX. Any other write is ignored.
- R7: Queue size, queue vector (0x1A), queue enable (0x1C) and the three ring addresses act on the queue named by queue select (half at 0x16). A select at or above NUM_QUEUES reads 0 from those registers, and writes to them are ignored.
- R8: Writing 0 to device status (byte at 0x14) returns every driver-writable register to its reset value. This covers both feature selects, the accepted features, the config vector, queue select, and every queue bank.
- R9: The ring addresses sit at 0x20 (descriptor), 0x28 (available) and 0x30 (used). Each is two word halves, low half at the lower address, that may be written in either order.
- R10: Queue enable stores bit 0 of the written value (1 enabled, 0 disabled). The notify offset (half at 0x1E) reads the selected queue's index.
- R11: The config vector (half at 0x10) and device status read back what was last written, and appear on cfg_vector_o and dev_status_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 write, 0 read |
| bus_addr | input | 6 | Byte address |
| bus_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| bus_be | input | 4 | Byte lane enables |
| bus_wdata | input | 32 | Write data on byte lanes |
| bus_rdata | output | 32 | Read data on byte lanes |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| drv_features_o | output | 64 | Features accepted by the driver |
| dev_status_o | output | 8 | Device status byte |
| cfg_vector_o | output | 16 | Configuration interrupt vector |
| q_size_o | output | NUM_QUEUES*16 | Ring size per queue |
| q_vector_o | output | NUM_QUEUES*16 | Interrupt vector per queue |
| q_enable_o | output | NUM_QUEUES | Enable flag per queue |
| q_desc_o | output | NUM_QUEUES*64 | Descriptor table address per queue |
| q_avail_o | output | NUM_QUEUES*64 | Available ring address per queue |
| q_used_o | output | NUM_QUEUES*64 | Used ring address per queue |

## Verification
The assertions assume that bus_valid, bus_write and the address, size and enable fields are driven to known values whenever the block is out of reset. They also assume that a read is judged only through bus_rvalid in the following cycle. The bench drives every input from a known idle state before it releases reset, and changes inputs only at falling edges. It holds each request for exactly one cycle and samples the returned data at the next falling edge. Illegal accesses are made deliberately only by a mismatched size, paired with the byte enables that size implies, so the address lanes stay consistent.

// File: rtl/pvcfg_pkg.sv
package pvcfg_pkg;

  typedef enum logic [3:0] {
    F_DFSEL, F_DFEAT, F_GFSEL, F_GFEAT, F_CFGVEC, F_NUMQ, F_STATUS, F_QSEL,
    F_QSIZE, F_QVEC, F_QEN, F_QNOFF, F_QDESC, F_QAVAIL, F_QUSED, F_NONE
  } cfg_field_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [1:0] SZ_NONE = 2'd3;

  // byte address -> field (word-aligned halves of 64-bit rings share a field)
  function automatic cfg_field_e field_at(input logic [5:0] a);
    case (a)
      6'h00: return F_DFSEL;
      6'h04: return F_DFEAT;
      6'h08: return F_GFSEL;
      6'h0C: return F_GFEAT;
      6'h10: return F_CFGVEC;
      6'h12: return F_NUMQ;
      6'h14: return F_STATUS;
      6'h16: return F_QSEL;
      6'h18: return F_QSIZE;
      6'h1A: return F_QVEC;
      6'h1C: return F_QEN;
      6'h1E: return F_QNOFF;
      6'h20, 6'h24: return F_QDESC;
      6'h28, 6'h2C: return F_QAVAIL;
      6'h30, 6'h34: return F_QUSED;
      default: return F_NONE;
    endcase
  endfunction

  function automatic logic [1:0] natural_size(input cfg_field_e f);
    case (f)
      F_DFSEL, F_DFEAT, F_GFSEL, F_GFEAT, F_QDESC, F_QAVAIL, F_QUSED: return SZ_WORD;
      F_STATUS: return SZ_BYTE;
      F_NONE:   return SZ_NONE;
      default:  return SZ_HALF;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] sz, input logic [1:0] off);
    logic [3:0] base;
    case (sz)
      SZ_BYTE: base = 4'b0001;
      SZ_HALF: base = 4'b0011;
      SZ_WORD: base = 4'b1111;
      default: base = 4'b0000;
    endcase
    return base << off;
  endfunction

  function automatic logic pow2_or_zero(input logic [15:0] v);
    return (v & (v - 16'd1)) == 16'd0;
  endfunction

endpackage

// File: rtl/pvcfg_decode.sv
module pvcfg_decode
  import pvcfg_pkg::*;
(
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [5:0]       bus_addr,
  input  logic [1:0]       bus_size,
  input  logic [3:0]       bus_be,
  input  logic [31:0]      bus_wdata,
  output cfg_field_e       field,
  output logic             acc_ok,
  output logic             wr_ok,
  output logic             rd_req,
  output logic             word_hi,
  output logic [31:0]      wdata_f
);
  logic [1:0] lane_off;

  assign lane_off = bus_addr[1:0];
  assign field    = field_at(bus_addr);
  assign acc_ok   = bus_valid && (field != F_NONE)
                    && (bus_size == natural_size(field))
                    && (bus_be == lane_mask(bus_size, lane_off));
  assign wr_ok    = acc_ok && bus_write;
  assign rd_req   = bus_valid && !bus_write;
  assign word_hi  = bus_addr[2];
  assign wdata_f  = bus_wdata >> {lane_off, 3'b000};
endmodule

// File: rtl/pvcfg_features.sv
module pvcfg_features #(
  parameter logic [63:0] DEV_FEATURES = 64'h0000_0000_1234_5678
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_reset,
  input  logic        wr_dsel,
  input  logic        wr_gsel,
  input  logic        wr_gfeat,
  input  logic [31:0] wdata,
  output logic [31:0] dsel,
  output logic [31:0] gsel,
  output logic [31:0] dev_word,
  output logic [31:0] drv_word,
  output logic [63:0] drv_features
);
  localparam logic [63:0] DEV_EFF = DEV_FEATURES | (64'h1 << 32);

  logic gsel_in_range;
  logic gfeat_dropped;

  assign gsel_in_range = (gsel == 32'd0) || (gsel == 32'd1);
  assign gfeat_dropped = wr_gfeat && !gsel_in_range;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsel <= '0; gsel <= '0; drv_features <= '0;
    end else if (sw_reset) begin
      dsel <= '0; gsel <= '0; drv_features <= '0;
    end else begin
      if (wr_dsel) dsel <= wdata;
      if (wr_gsel) gsel <= wdata;
      if (wr_gfeat && gsel_in_range) begin
        if (gsel[0]) drv_features[63:32] <= wdata;
        else         drv_features[31:0]  <= wdata;
      end
    end
  end

  always_comb begin
    case (dsel)
      32'd0:   dev_word = DEV_EFF[31:0];
      32'd1:   dev_word = DEV_EFF[63:32];
      default: dev_word = '0;
    endcase
    case (gsel)
      32'd0:   drv_word = drv_features[31:0];
      32'd1:   drv_word = drv_features[63:32];
      default: drv_word = '0;
    endcase
  end

  assert_drop_gfeat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gfeat_dropped && !sw_reset) |=> $stable(drv_features));

  assert_sw_reset_feat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> (drv_features == 64'd0 && gsel == 32'd0 && dsel == 32'd0));

  assert_bit32_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dsel == 32'd1) |-> dev_word[0]);
endmodule

// File: rtl/pvcfg_qbank.sv
module pvcfg_qbank
  import pvcfg_pkg::*;
#(
  parameter int NUM_QUEUES = 4,
  parameter int QSIZE_MAX  = 256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sw_reset,
  input  logic                    wr_ok,
  input  cfg_field_e              field,
  input  logic                    word_hi,
  input  logic [31:0]             wdata,
  input  logic [15:0]             qsel,
  output logic [31:0]             rd_data,
  output logic [NUM_QUEUES*16-1:0] q_size_o,
  output logic [NUM_QUEUES*16-1:0] q_vector_o,
  output logic [NUM_QUEUES-1:0]    q_enable_o,
  output logic [NUM_QUEUES*64-1:0] q_desc_o,
  output logic [NUM_QUEUES*64-1:0] q_avail_o,
  output logic [NUM_QUEUES*64-1:0] q_used_o
);
  localparam int QW = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1;
  localparam logic [15:0] SZ_RST = 16'(QSIZE_MAX);

  logic          sel_ok;
  logic          size_wr_ok;
  logic [QW-1:0] qidx;
  int            qi;

  assign sel_ok     = qsel < 16'(NUM_QUEUES);
  assign size_wr_ok = pow2_or_zero(wdata[15:0]) && (wdata[15:0] <= SZ_RST);
  assign qidx       = qsel[QW-1:0];
  assign qi         = int'(qidx);

  for (genvar i = 0; i < NUM_QUEUES; i++) begin : g_q
    logic        hit;
    logic [15:0] size_r, vec_r;
    logic        en_r;
    logic [63:0] desc_r, avail_r, used_r;

    assign hit = wr_ok && sel_ok && (qsel == 16'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        size_r <= SZ_RST; vec_r <= '0; en_r <= 1'b0;
        desc_r <= '0; avail_r <= '0; used_r <= '0;
      end else if (sw_reset) begin
        size_r <= SZ_RST; vec_r <= '0; en_r <= 1'b0;
        desc_r <= '0; avail_r <= '0; used_r <= '0;
      end else if (hit) begin
        case (field)
          F_QSIZE:  if (size_wr_ok) size_r <= wdata[15:0];
          F_QVEC:   vec_r <= wdata[15:0];
          F_QEN:    en_r  <= wdata[0];
          F_QDESC:  if (word_hi) desc_r[63:32]  <= wdata; else desc_r[31:0]  <= wdata;
          F_QAVAIL: if (word_hi) avail_r[63:32] <= wdata; else avail_r[31:0] <= wdata;
          F_QUSED:  if (word_hi) used_r[63:32]  <= wdata; else used_r[31:0]  <= wdata;
          default: ;
        endcase
      end
    end

    assign q_size_o[i*16 +: 16]   = size_r;
    assign q_vector_o[i*16 +: 16] = vec_r;
    assign q_enable_o[i]          = en_r;
    assign q_desc_o[i*64 +: 64]   = desc_r;
    assign q_avail_o[i*64 +: 64]  = avail_r;
    assign q_used_o[i*64 +: 64]   = used_r;

    assert_qsize_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(size_r) <= 1) && (size_r <= SZ_RST));
  end

  always_comb begin
    rd_data = '0;
    if (sel_ok) begin
      case (field)
        F_QSIZE:  rd_data = {16'h0, q_size_o[qi*16 +: 16]};
        F_QVEC:   rd_data = {16'h0, q_vector_o[qi*16 +: 16]};
        F_QEN:    rd_data = {31'h0, q_enable_o[qi]};
        F_QNOFF:  rd_data = {16'h0, qsel};
        F_QDESC:  rd_data = word_hi ? q_desc_o[qi*64+32 +: 32]  : q_desc_o[qi*64 +: 32];
        F_QAVAIL: rd_data = word_hi ? q_avail_o[qi*64+32 +: 32] : q_avail_o[qi*64 +: 32];
        F_QUSED:  rd_data = word_hi ? q_used_o[qi*64+32 +: 32]  : q_used_o[qi*64 +: 32];
        default:  rd_data = '0;
      endcase
    end
  end

  assert_oob_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !sel_ok && !sw_reset) |=>
      $stable({q_size_o, q_vector_o, q_enable_o, q_desc_o, q_avail_o, q_used_o}));

  assert_bad_size_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && field == F_QSIZE && !size_wr_ok && !sw_reset) |=> $stable(q_size_o));
endmodule

// File: rtl/pvdev_common_cfg.sv
module pvdev_common_cfg
  import pvcfg_pkg::*;
#(
  parameter int          NUM_QUEUES   = 4,
  parameter int          QSIZE_MAX    = 256,
  parameter logic [63:0] DEV_FEATURES = 64'h0000_0000_1234_5678
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_valid,
  input  logic                     bus_write,
  input  logic [5:0]               bus_addr,
  input  logic [1:0]               bus_size,
  input  logic [3:0]               bus_be,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  output logic                     bus_rvalid,
  output logic [63:0]              drv_features_o,
  output logic [7:0]               dev_status_o,
  output logic [15:0]              cfg_vector_o,
  output logic [NUM_QUEUES*16-1:0] q_size_o,
  output logic [NUM_QUEUES*16-1:0] q_vector_o,
  output logic [NUM_QUEUES-1:0]    q_enable_o,
  output logic [NUM_QUEUES*64-1:0] q_desc_o,
  output logic [NUM_QUEUES*64-1:0] q_avail_o,
  output logic [NUM_QUEUES*64-1:0] q_used_o
);
  cfg_field_e  field;
  logic        acc_ok, wr_ok, rd_req, word_hi, sw_reset;
  logic [31:0] wdata_f, dsel, gsel, dev_word, drv_word, q_rd, field_val;
  logic [15:0] qsel;

  pvcfg_decode u_dec (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .field(field), .acc_ok(acc_ok), .wr_ok(wr_ok), .rd_req(rd_req),
    .word_hi(word_hi), .wdata_f(wdata_f)
  );

  assign sw_reset = wr_ok && (field == F_STATUS) && (wdata_f[7:0] == 8'h00);

  pvcfg_features #(.DEV_FEATURES(DEV_FEATURES)) u_feat (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset),
    .wr_dsel(wr_ok && field == F_DFSEL), .wr_gsel(wr_ok && field == F_GFSEL),
    .wr_gfeat(wr_ok && field == F_GFEAT), .wdata(wdata_f),
    .dsel(dsel), .gsel(gsel), .dev_word(dev_word), .drv_word(drv_word),
    .drv_features(drv_features_o)
  );

  pvcfg_qbank #(.NUM_QUEUES(NUM_QUEUES), .QSIZE_MAX(QSIZE_MAX)) u_qbank (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .wr_ok(wr_ok),
    .field(field), .word_hi(word_hi), .wdata(wdata_f), .qsel(qsel),
    .rd_data(q_rd), .q_size_o(q_size_o), .q_vector_o(q_vector_o),
    .q_enable_o(q_enable_o), .q_desc_o(q_desc_o), .q_avail_o(q_avail_o),
    .q_used_o(q_used_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_vector_o <= '0; dev_status_o <= '0; qsel <= '0;
    end else if (sw_reset) begin
      cfg_vector_o <= '0; dev_status_o <= '0; qsel <= '0;
    end else if (wr_ok) begin
      case (field)
        F_CFGVEC: cfg_vector_o <= wdata_f[15:0];
        F_STATUS: dev_status_o <= wdata_f[7:0];
        F_QSEL:   qsel         <= wdata_f[15:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (field)
      F_DFSEL:  field_val = dsel;
      F_DFEAT:  field_val = dev_word;
      F_GFSEL:  field_val = gsel;
      F_GFEAT:  field_val = drv_word;
      F_CFGVEC: field_val = {16'h0, cfg_vector_o};
      F_NUMQ:   field_val = 32'(NUM_QUEUES);
      F_STATUS: field_val = {24'h0, dev_status_o};
      F_QSEL:   field_val = {16'h0, qsel};
      F_QSIZE, F_QVEC, F_QEN, F_QNOFF, F_QDESC, F_QAVAIL, F_QUSED: field_val = q_rd;
      default:  field_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0; bus_rdata <= '0;
    end else begin
      bus_rvalid <= rd_req;
      bus_rdata  <= (rd_req && acc_ok) ? (field_val << {bus_addr[1:0], 3'b000}) : 32'h0;
    end
  end

  assert_rd_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid);

  assert_bad_access_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !acc_ok) |=> (bus_rdata == 32'h0));

  assert_status_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ok && field == F_STATUS) |=> $stable(dev_status_o));
endmodule

// File: tb/pvdev_common_cfg_tb_top.sv
module pvdev_common_cfg_tb_top;
  localparam int NQ = 4;
  localparam int QMAX = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 0, bus_write = 0;
  logic [5:0] bus_addr = 0;
  logic [1:0] bus_size = 0;
  logic [3:0] bus_be = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic bus_rvalid;
  logic [63:0] drv_features_o;
  logic [7:0] dev_status_o;
  logic [15:0] cfg_vector_o;
  logic [NQ*16-1:0] q_size_o, q_vector_o;
  logic [NQ-1:0] q_enable_o;
  logic [NQ*64-1:0] q_desc_o, q_avail_o, q_used_o;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pvdev_common_cfg #(.NUM_QUEUES(NQ), .QSIZE_MAX(QMAX)) dut_i (.*);

  function automatic logic [3:0] mask_of(input logic [1:0] sz, input logic [1:0] off);
    logic [3:0] m;
    m = (sz == 2'd0) ? 4'h1 : (sz == 2'd1) ? 4'h3 : 4'hF;
    return m << off;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [1:0] sz, input logic [31:0] v);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_size = sz;
    bus_be = mask_of(sz, a[1:0]); bus_wdata = v << (8 * a[1:0]);
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [1:0] sz, output logic [31:0] v);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a; bus_size = sz;
    bus_be = mask_of(sz, a[1:0]); bus_wdata = 0;
    @(negedge clk);
    bus_valid = 0;
    chk("R1 rvalid", {63'h0, bus_rvalid}, 64'h1);
    v = bus_rdata >> (8 * a[1:0]);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(6'h12, 1, v); chk("R5 queue count", v, NQ);
    rd(6'h14, 0, v); chk("R8 status reset", v, 0);
    rd(6'h18, 1, v); chk("R6 size reset", v, QMAX);
    chk("R6 size port reset", q_size_o[3*16 +: 16], QMAX);
  endtask

  task automatic t_dev_feat();
    logic [31:0] v;
    wr(6'h00, 2, 0); rd(6'h04, 2, v); chk("R2 dev low", v, 32'h1234_5678);
    wr(6'h00, 2, 1); rd(6'h04, 2, v); chk("R3 bit32 set", v, 32'h1);
    wr(6'h00, 2, 7); rd(6'h04, 2, v); chk("R2 out of range", v, 0);
  endtask

  task automatic t_drv_feat();
    logic [31:0] v;
    wr(6'h08, 2, 0); wr(6'h0C, 2, 32'hA5A5_A5A5);
    wr(6'h08, 2, 1); wr(6'h0C, 2, 32'h0000_00FF);
    chk("R4 accepted port", drv_features_o, 64'h0000_00FF_A5A5_A5A5);
    wr(6'h08, 2, 2); wr(6'h0C, 2, 32'hFFFF_FFFF);
    rd(6'h0C, 2, v); chk("R4 bad select reads 0", v, 0);
    chk("R4 bad select write ignored", drv_features_o, 64'h0000_00FF_A5A5_A5A5);
    wr(6'h08, 2, 0); rd(6'h0C, 2, v); chk("R4 low readback", v, 32'hA5A5_A5A5);
  endtask

  task automatic t_width();
    logic [31:0] v;
    wr(6'h00, 2, 1);
    wr(6'h00, 1, 0);
    rd(6'h04, 2, v); chk("R1 half write to word ignored", v, 1);
    rd(6'h12, 2, v); chk("R1 wrong size read 0", v, 0);
    wr(6'h12, 1, 16'h00FF); rd(6'h12, 1, v); chk("R5 count read-only", v, NQ);
    wr(6'h04, 2, 0); rd(6'h04, 2, v); chk("R5 dev feature read-only", v, 1);
    wr(6'h10, 1, 16'hBEEF); rd(6'h10, 1, v); chk("R11 cfg vector", v, 16'hBEEF);
    chk("R11 cfg vector port", cfg_vector_o, 16'hBEEF);
    wr(6'h14, 0, 8'h0F); chk("R11 status port", dev_status_o, 8'h0F);
  endtask

  task automatic t_queue();
    logic [31:0] v;
    wr(6'h16, 1, 1);
    wr(6'h18, 1, 64);  rd(6'h18, 1, v); chk("R6 size 64", v, 64);
    wr(6'h18, 1, 100); rd(6'h18, 1, v); chk("R6 non-pow2 ignored", v, 64);
    wr(6'h18, 1, 512); rd(6'h18, 1, v); chk("R6 above max ignored", v, 64);
    wr(6'h18, 1, 0);   rd(6'h18, 1, v); chk("R6 zero accepted", v, 0);
    wr(6'h16, 1, 2);
    rd(6'h18, 1, v); chk("R7 bank 2 untouched", v, QMAX);
    wr(6'h1A, 1, 16'h1234); rd(6'h1A, 1, v); chk("R7 queue vector", v, 16'h1234);
    wr(6'h1C, 1, 3); rd(6'h1C, 1, v); chk("R10 enable bit0", v, 1);
    chk("R10 enable port", q_enable_o, 4'b0100);
    rd(6'h1E, 1, v); chk("R10 notify offset", v, 2);
    wr(6'h1E, 1, 9); rd(6'h1E, 1, v); chk("R5 notify read-only", v, 2);
    chk("R7 size port q1", q_size_o[1*16 +: 16], 0);
  endtask

  task automatic t_addr();
    logic [31:0] v;
    wr(6'h16, 1, 3);
    wr(6'h24, 2, 32'hDEAD_0001); wr(6'h20, 2, 32'h1000_2000);
    chk("R9 desc hi-then-lo", q_desc_o[3*64 +: 64], 64'hDEAD_0001_1000_2000);
    wr(6'h28, 2, 32'h3000_4000); wr(6'h2C, 2, 32'h0000_0005);
    chk("R9 avail lo-then-hi", q_avail_o[3*64 +: 64], 64'h0000_0005_3000_4000);
    wr(6'h34, 2, 32'h7777_8888);
    rd(6'h34, 2, v); chk("R9 used hi readback", v, 32'h7777_8888);
    rd(6'h30, 2, v); chk("R9 used lo readback", v, 0);
  endtask

  task automatic t_oob();
    logic [31:0] v;
    logic [NQ*(16+16+1+64*3)-1:0] snap;
    wr(6'h16, 1, NQ);
    snap = {q_size_o, q_vector_o, q_enable_o, q_desc_o, q_avail_o, q_used_o};
    rd(6'h18, 1, v); chk("R7 oob size reads 0", v, 0);
    rd(6'h1E, 1, v); chk("R7 oob notify reads 0", v, 0);
    wr(6'h18, 1, 16); wr(6'h1A, 1, 16'h5555); wr(6'h20, 2, 32'hFFFF_FFFF);
    chk("R7 oob writes ignored", {q_size_o, q_vector_o, q_enable_o, q_desc_o, q_avail_o, q_used_o}, snap);
  endtask

  task automatic t_softreset();
    logic [31:0] v;
    wr(6'h14, 0, 0);
    chk("R8 features cleared", drv_features_o, 0);
    chk("R8 cfg vector cleared", cfg_vector_o, 0);
    chk("R8 desc cleared", q_desc_o[3*64 +: 64], 0);
    chk("R8 enable cleared", q_enable_o, 0);
    rd(6'h16, 1, v); chk("R8 queue select cleared", v, 0);
    wr(6'h16, 1, 1); rd(6'h18, 1, v); chk("R8 size back to max", v, QMAX);
    rd(6'h00, 2, v); chk("R8 device select cleared", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_dev_feat();
    t_drv_feat();
    t_width();
    t_queue();
    t_addr();
    t_oob();
    t_softreset();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule